// File: doc/BRIEF.md
# Voted-Feedback Triple Counter

This block is a free-running binary counter built to survive single-event upsets in its state flops. The count is held in three identical register copies. Each copy has its own bitwise 2-of-3 majority voter that reads all three registers. Each copy computes its next value from its own voter's output and not from its own register. A copy whose bits have been flipped is therefore overwritten with the agreed value at the next clock edge, and the count keeps advancing while the repair happens.

The block has a plain control interface. A synchronous active-high reset clears all three copies. An enable input advances the count by one on each clock. Three fault-injection inputs, one per copy, each XOR a bit pattern into the value that copy loads on that edge, which emulates an upset for test. The voted count and a flag that reports disagreement between the copies are brought out. The design has no data stream, so it has no valid/ready handshake, and the output is valid on every cycle.

Top module: `trc_counter`

## Requirements
- R1: While `rst` is high at a clock edge, all three copies load zero. After that edge `count` is 0 and `mismatch` is 0, whatever the enable and injection inputs are doing.
- R2: With `en` high and no injection, `count` rises by exactly one on each clock edge.
- R3: With `en` low, `count` keeps its value across clock edges.
- R4: The count wraps from 2^W-1 to 0 on the next enabled edge.
- R5: Injecting any nonzero pattern into exactly one copy leaves `count` equal to the value it would have had without the injection, on the edge of the injection and on every edge after it.
- R6: `mismatch` is 1 in the cycle after an edge in which the three copies loaded values that are not all equal, for example after a nonzero injection into one copy only.
- R7: After any edge with no injection, all three copies are equal, so `mismatch` is 0. A single upset copy is therefore repaired within one clock, and the count keeps going.
- R8: Upsets in different bit positions of different copies at the same edge are all masked, because the vote is taken bit by bit.
- R9: If two copies receive the same flipped bit at the same edge, `count` takes the flipped value. On the next edge the copies realign to that value, and counting continues from it.
- R10: The injection patterns are `flip_a`, `flip_b` and `flip_c`, one bit per count bit. Bit i set flips bit i of that copy's loaded value for that edge only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset of all three copies |
| en | input | 1 | Advance the count by one on this edge |
| flip_a | input | W | XOR pattern applied to copy A's loaded value |
| flip_b | input | W | XOR pattern applied to copy B's loaded value |
| flip_c | input | W | XOR pattern applied to copy C's loaded value |
| count | output | W | Majority-voted count |
| mismatch | output | 1 | High while the three copies disagree |

## Verification
The bench injects upsets into each copy in turn, both while counting and while holding. A design that fed a copy from its own register would leave `mismatch` stuck high, and a design that voted only at the output would never repair the copy. Disjoint-bit upsets in all three copies at once catch a voter that works on whole words rather than bit by bit. A same-bit double upset checks that the copies settle on the corrupted value instead of splitting apart. The wrap from all-ones and reset held during an injection complete the corner cases.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int unsigned NCOPY = 3;

  // bitwise two-out-of-three majority
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/trc_voter.sv
module trc_voter
  import trc_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] y
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign y[i] = maj3(a[i], b[i], c[i]);
  end
endmodule

// File: rtl/trc_lane.sv
module trc_lane
  import trc_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic [W-1:0]             upset,
  input  logic [NCOPY-1:0][W-1:0]  all_q,
  output logic [W-1:0]             q,
  output logic [W-1:0]             voted
);
  logic [W-1:0] nxt;

  trc_voter #(.W(W)) u_vote (
    .a(all_q[0]),
    .b(all_q[1]),
    .c(all_q[2]),
    .y(voted)
  );

  // next state is formed from the vote, never from this lane's own flop
  always_comb begin
    nxt = en ? voted + W'(1) : voted;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt ^ upset;
  end
endmodule

// File: rtl/trc_mismatch.sv
module trc_mismatch
  import trc_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [NCOPY-1:0][W-1:0] all_q,
  output logic                    differ
);
  assign differ = (all_q[0] != all_q[1]) | (all_q[1] != all_q[2]);
endmodule

// File: rtl/trc_counter.sv
module trc_counter
  import trc_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] flip_a,
  input  logic [W-1:0] flip_b,
  input  logic [W-1:0] flip_c,
  output logic [W-1:0] count,
  output logic         mismatch
);
  logic [NCOPY-1:0][W-1:0] regs;
  logic [NCOPY-1:0][W-1:0] votes;
  logic [NCOPY-1:0][W-1:0] upsets;

  assign upsets = {flip_c, flip_b, flip_a};

  for (genvar k = 0; k < NCOPY; k++) begin : g_copy
    trc_lane #(.W(W)) u_lane (
      .clk  (clk),
      .rst  (rst),
      .en   (en),
      .upset(upsets[k]),
      .all_q(regs),
      .q    (regs[k]),
      .voted(votes[k])
    );
  end

  trc_mismatch #(.W(W)) u_cmp (
    .all_q (regs),
    .differ(mismatch)
  );

  // copy A's voter drives the port; all three voters see identical inputs
  assign count = votes[0];
endmodule

// File: rtl/trc_counter_chk.sv
module trc_counter_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         en,
  input logic [W-1:0] flip_a,
  input logic [W-1:0] flip_b,
  input logic [W-1:0] flip_c,
  input logic [W-1:0] count,
  input logic         mismatch
);
  logic [W-1:0] overlap;
  logic         any_flip;
  logic         uneven;
  assign overlap  = (flip_a & flip_b) | (flip_a & flip_c) | (flip_b & flip_c);
  assign any_flip = |{flip_a, flip_b, flip_c};
  assign uneven   = (flip_a != flip_b) || (flip_b != flip_c);

  // R1
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (count == '0 && !mismatch));

  // R2, R5, R8
  a_r2_increment: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(en) && $past(overlap) == '0) |-> count == $past(count) + W'(1));

  // R3
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(en) && $past(overlap) == '0) |-> count == $past(count));

  // R6
  a_r6_flag_on_upset: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(uneven)) |-> mismatch);

  // R7
  a_r7_repaired: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(any_flip)) |-> !mismatch);
endmodule

bind trc_counter trc_counter_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .en      (en),
  .flip_a  (flip_a),
  .flip_b  (flip_b),
  .flip_c  (flip_c),
  .count   (count),
  .mismatch(mismatch)
);

// File: tb/test_trc_counter.sv
module test_trc_counter;
  localparam int unsigned W = 8;
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic         clk = 1'b0;
  logic         rst;
  logic         en;
  logic [W-1:0] flip_a, flip_b, flip_c;
  logic [W-1:0] count;
  logic         mismatch;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [W-1:0] exp;

  always #10 clk = ~clk;

  trc_counter #(.W(W)) i_trc_counter (
    .clk(clk), .rst(rst), .en(en),
    .flip_a(flip_a), .flip_b(flip_b), .flip_c(flip_c),
    .count(count), .mismatch(mismatch)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] want);
    checks++;
    if (act !== want) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, want);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_flips();
    flip_a = '0; flip_b = '0; flip_c = '0;
  endtask

  task automatic t_reset();
    rst = 1'b1; en = 1'b0; clear_flips();
    step(); step();
    rst = 1'b0;
    exp = '0;
    chk("R1 count", 32'(count), 32'(exp));
    chk("R1 mismatch", 32'(mismatch), 0);
  endtask

  task automatic t_count(input int n);
    en = 1'b1;
    for (int i = 0; i < n; i++) begin
      step(); exp = exp + 1'b1;
      chk("R2 count", 32'(count), 32'(exp));
    end
  endtask

  task automatic t_hold();
    en = 1'b0;
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R3 count", 32'(count), 32'(exp));
    end
  endtask

  task automatic t_wrap();
    en = 1'b1;
    while (exp != TOP) begin step(); exp = exp + 1'b1; end
    chk("R4 at top", 32'(count), 32'(TOP));
    step(); exp = '0;
    chk("R4 wrapped", 32'(count), 0);
  endtask

  task automatic t_single(input int which, input logic e, input logic [W-1:0] pat);
    en = e;
    if (which == 0) flip_a = pat; else if (which == 1) flip_b = pat; else flip_c = pat;
    step(); if (e) exp = exp + 1'b1;
    clear_flips();
    chk("R5 masked", 32'(count), 32'(exp));
    chk("R6 flag", 32'(mismatch), 1);
    step(); if (e) exp = exp + 1'b1;
    chk("R7 repaired flag", 32'(mismatch), 0);
    chk("R7 count", 32'(count), 32'(exp));
  endtask

  task automatic t_disjoint();
    en = 1'b1;
    flip_a = 8'h81; flip_b = 8'h42; flip_c = 8'h24;
    step(); exp = exp + 1'b1; clear_flips();
    chk("R8 masked", 32'(count), 32'(exp));
    chk("R8 flag", 32'(mismatch), 1);
    step(); exp = exp + 1'b1;
    chk("R8 repaired", 32'(mismatch), 0);
  endtask

  task automatic t_double();
    en = 1'b1;
    flip_a = 8'h10; flip_c = 8'h10;
    step(); exp = (exp + 1'b1) ^ 8'h10; clear_flips();
    chk("R9 corrupted", 32'(count), 32'(exp));
    chk("R9 flag", 32'(mismatch), 1);
    step(); exp = exp + 1'b1;
    chk("R9 realigned", 32'(mismatch), 0);
    chk("R9 count", 32'(count), 32'(exp));
  endtask

  task automatic t_reset_wins();
    en = 1'b1; rst = 1'b1;
    flip_a = 8'hFF; flip_b = 8'h0F;
    step(); clear_flips(); rst = 1'b0; exp = '0;
    chk("R1 reset over flips", 32'(count), 0);
    chk("R1 reset flag", 32'(mismatch), 0);
  endtask

  initial begin
    t_reset();
    t_count(5);
    t_hold();
    t_single(0, 1'b1, 8'h5A);   // R10 copy A
    t_single(1, 1'b1, 8'hFF);   // R10 copy B
    t_single(2, 1'b0, 8'h01);   // R10 copy C while holding
    t_disjoint();
    t_double();
    t_wrap();
    t_count(3);
    t_reset_wins();
    t_count(2);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule